// File: doc/BRIEF.md
# System Power State Sequencer

This block turns a host's sleep-state signalling into a system power state and brings a fixed set of eight supply rails up or down to match it. Its inputs are an enable pin, three active-low sleep lines (deep, mid and idle), an active-low thermal trip line, a memory-type configuration bit, a per-rail disable mask and per-rail power-good inputs. Its outputs are the rail enables and two handshakes: a wake release, which means the standby rails are up, and a platform-OK, which means the system is fully on.

Rails are switched one at a time. Going up, the block turns on a rail and then waits for its power-good or for a programmable timeout before it turns on the next one. Going down, it turns off one rail per cycle, highest index first. During start-up some inputs are given assumed values until the handshakes first rise. A thermal trip or the loss of an established power-good turns everything off in a single cycle, and the block then stays off until the enable pin is dropped.

Top module: `pwr_state_seq`

## Requirements
- R1: The state is decoded by priority from the qualified inputs. It is OFF if the block is not ready or en_pin_i is low; otherwise SOFT if deep is low, else SUSPEND if mid is low, else IDLE if idle is low, else ON. wake_rel_o rises when the rails match the target in any state other than OFF, and it falls in OFF. plat_ok_o rises when the rails match the target in ON or IDLE, and it falls in any other state. plat_ok_o is never high while wake_rel_o is low.
- R2: After en_pin_i rises, sleep_deep_n_i and sleep_mid_n_i are treated as low until wake_rel_o first goes high.
- R3: After en_pin_i rises, sleep_idle_n_i is treated as high until plat_ok_o first goes high.
- R4: trip_n_i is ignored until wake_rel_o first goes high. Both of these "first rise" memories are cleared while en_pin_i is low.
- R5: Rail bit map: bit0 rail 1, bit1 rail 2, bit2 rail 3, bit3 rail 4, bit4 rail 5, bit5 memory rail, bit6 switched rail, bit7 termination rail. The rail sets are: SOFT 0x19; SUSPEND 0x39, plus bit6 when mem_lp_i=1; ON 0xFF; IDLE 0x78 (ON without bits 0, 1, 2 and 7).
- R6: A rail whose rail_dis_i bit is set is never switched on.
- R7: With auto_start_i=1, ready_o rises once int_pg_i is high. With auto_start_i=0, it also needs en_pin_i high. ready_o falls when int_pg_i falls. No rail is switched on while the block is not ready.
- R8: At most one rail is switched on per cycle, lowest index first. After each switch-on the block waits until that rail's power-good is seen, or for step_tmo_i+1 cycles, before it switches on the next rail.
- R9: Rails that leave the target are switched off one per cycle, highest index first.
- R10: A low qualified trip_n_i, or a low power-good on an enabled rail that had already reported good, clears all rail enables, wake_rel_o and plat_ok_o on the next edge.
- R11: fault_o rises with that shutdown and stays high, with all rails off, until en_pin_i is low.
- R12: A synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| int_pg_i | input | 1 | Internal supplies good |
| auto_start_i | input | 1 | 1: become ready without the enable pin |
| en_pin_i | input | 1 | Block enable |
| sleep_deep_n_i | input | 1 | Deep sleep request, active low |
| sleep_mid_n_i | input | 1 | Suspend request, active low |
| sleep_idle_n_i | input | 1 | Idle request, active low |
| trip_n_i | input | 1 | Thermal trip, active low |
| mem_lp_i | input | 1 | Memory type: switched rail joins in SUSPEND when 1 |
| rail_dis_i | input | 8 | Per-rail disable mask |
| rail_pg_i | input | 8 | Per-rail power-good |
| step_tmo_i | input | TMO_W | Power-good wait limit per step |
| rails_o | output | 8 | Rail enables |
| wake_rel_o | output | 1 | Wake release handshake |
| plat_ok_o | output | 1 | Platform power OK |
| fault_o | output | 1 | Latched emergency shutdown |
| ready_o | output | 1 | Block out of internal reset |

## Verification
Emergency shutdown can fall in the same cycle as a sequencing step. The trip input becomes effective one cycle after wake_rel_o first rises, and at that point the block is already stepping rails up toward ON. A power-good drop that is forced while the rails are active also lands on an edge where the stepper could act. The bench provokes both cases and compares every output, on every clock, with a behavioural model in which the kill takes priority over the step. Waits that end by timeout rather than by power-good come from a rail whose power-good never rises.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned RAIL_N = 8;
  localparam int unsigned IDX_W  = $clog2(RAIL_N);

  typedef enum logic [2:0] {PS_OFF, PS_SOFT, PS_SUSP, PS_IDLE, PS_ON} pstate_e;

  // rail roles by bit position
  localparam logic [RAIL_N-1:0] SET_BASE  = 8'b0001_1001; // rails 1,4,5
  localparam logic [RAIL_N-1:0] MEM_RAIL  = 8'b0010_0000;
  localparam logic [RAIL_N-1:0] SW_RAIL   = 8'b0100_0000;
  localparam logic [RAIL_N-1:0] ADD_FULL  = 8'b1000_0110; // rails 2,3, termination
  localparam logic [RAIL_N-1:0] IDLE_OFF  = 8'b1000_0111; // removed in idle

  function automatic logic [RAIL_N-1:0] rail_set(pstate_e s, logic lp);
    logic [RAIL_N-1:0] full;
    full = SET_BASE | MEM_RAIL | SW_RAIL | ADD_FULL;
    case (s)
      PS_SOFT: rail_set = SET_BASE;
      PS_SUSP: rail_set = SET_BASE | MEM_RAIL | (lp ? SW_RAIL : '0);
      PS_ON:   rail_set = full;
      PS_IDLE: rail_set = full & ~IDLE_OFF;
      default: rail_set = '0;
    endcase
  endfunction
endpackage

// File: rtl/pss_qualify.sv
module pss_qualify (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_pin_i,
  input  logic wake_i,
  input  logic ok_i,
  input  logic deep_n_i,
  input  logic mid_n_i,
  input  logic idle_n_i,
  input  logic trip_n_i,
  output logic q_deep_o,
  output logic q_mid_o,
  output logic q_idle_o,
  output logic q_trip_n_o
);
  logic wake_seen_q, ok_seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_pin_i) begin
      wake_seen_q <= 1'b0;
      ok_seen_q   <= 1'b0;
    end else begin
      wake_seen_q <= wake_seen_q | wake_i;
      ok_seen_q   <= ok_seen_q | ok_i;
    end
  end

  assign q_deep_o   = wake_seen_q & deep_n_i;
  assign q_mid_o    = wake_seen_q & mid_n_i;
  assign q_idle_o   = ~ok_seen_q | idle_n_i;
  assign q_trip_n_o = ~wake_seen_q | trip_n_i;
endmodule

// File: rtl/pss_decode.sv
module pss_decode
  import pss_pkg::*;
(
  input  logic              active_i,
  input  logic              en_pin_i,
  input  logic              q_deep_i,
  input  logic              q_mid_i,
  input  logic              q_idle_i,
  input  logic              mem_lp_i,
  input  logic [RAIL_N-1:0] dis_i,
  output pstate_e           state_o,
  output logic [RAIL_N-1:0] target_o
);
  always_comb begin
    if (!active_i || !en_pin_i) state_o = PS_OFF;
    else if (!q_deep_i)         state_o = PS_SOFT;
    else if (!q_mid_i)          state_o = PS_SUSP;
    else if (!q_idle_i)         state_o = PS_IDLE;
    else                        state_o = PS_ON;
    target_o = rail_set(state_o, mem_lp_i) & ~dis_i;
  end
endmodule

// File: rtl/pss_stepper.sv
module pss_stepper
  import pss_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              kill_i,
  input  logic [RAIL_N-1:0] target_i,
  input  logic [RAIL_N-1:0] pg_i,
  input  logic [TMO_W-1:0]  tmo_i,
  output logic [RAIL_N-1:0] rails_o,
  output logic              busy_o,
  output logic              drop_o
);
  logic [RAIL_N-1:0] en_q, en_n, good_q, good_n, up, dn;
  logic              busy_q, busy_n;
  logic [IDX_W-1:0]  idx_q, idx_n, up_k, dn_k;
  logic [TMO_W-1:0]  cnt_q, cnt_n;

  assign up = target_i & ~en_q;
  assign dn = en_q & ~target_i;

  always_comb begin
    up_k = '0;
    for (int i = RAIL_N - 1; i >= 0; i--)
      if (up[i]) up_k = IDX_W'(i);
    dn_k = '0;
    for (int i = 0; i < RAIL_N; i++)
      if (dn[i]) dn_k = IDX_W'(i);
  end

  always_comb begin
    en_n   = en_q;
    busy_n = busy_q;
    idx_n  = idx_q;
    cnt_n  = cnt_q;
    if (kill_i) begin
      en_n   = '0;
      busy_n = 1'b0;
    end else if (busy_q) begin
      if (pg_i[idx_q] || cnt_q == tmo_i) busy_n = 1'b0;
      else                               cnt_n  = cnt_q + 1'b1;
    end else if (|up) begin
      en_n[up_k] = 1'b1;
      busy_n     = 1'b1;
      idx_n      = up_k;
      cnt_n      = '0;
    end else if (|dn) begin
      en_n[dn_k] = 1'b0;
    end
    good_n = (good_q | (en_q & pg_i)) & en_n;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q   <= '0;
      good_q <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
    end else begin
      en_q   <= en_n;
      good_q <= good_n;
      busy_q <= busy_n;
      idx_q  <= idx_n;
      cnt_q  <= cnt_n;
    end
  end

  assign rails_o = en_q;
  assign busy_o  = busy_q;
  assign drop_o  = |(good_q & en_q & ~pg_i);
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pss_pkg::*;
#(
  parameter int unsigned TMO_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              int_pg_i,
  input  logic              auto_start_i,
  input  logic              en_pin_i,
  input  logic              sleep_deep_n_i,
  input  logic              sleep_mid_n_i,
  input  logic              sleep_idle_n_i,
  input  logic              trip_n_i,
  input  logic              mem_lp_i,
  input  logic [RAIL_N-1:0] rail_dis_i,
  input  logic [RAIL_N-1:0] rail_pg_i,
  input  logic [TMO_W-1:0]  step_tmo_i,
  output logic [RAIL_N-1:0] rails_o,
  output logic              wake_rel_o,
  output logic              plat_ok_o,
  output logic              fault_o,
  output logic              ready_o
);
  logic              active_q, fault_q, wake_q, ok_q;
  logic              q_deep, q_mid, q_idle, q_trip_n;
  logic              busy, drop, fault_set, kill, settled;
  pstate_e           state;
  logic [RAIL_N-1:0] target, rails;

  pss_qualify u_qual (
    .clk_i(clk_i), .rst_i(rst_i), .en_pin_i(en_pin_i),
    .wake_i(wake_q), .ok_i(ok_q),
    .deep_n_i(sleep_deep_n_i), .mid_n_i(sleep_mid_n_i),
    .idle_n_i(sleep_idle_n_i), .trip_n_i(trip_n_i),
    .q_deep_o(q_deep), .q_mid_o(q_mid), .q_idle_o(q_idle),
    .q_trip_n_o(q_trip_n)
  );

  pss_decode u_dec (
    .active_i(active_q), .en_pin_i(en_pin_i),
    .q_deep_i(q_deep), .q_mid_i(q_mid), .q_idle_i(q_idle),
    .mem_lp_i(mem_lp_i), .dis_i(rail_dis_i),
    .state_o(state), .target_o(target)
  );

  assign fault_set = active_q & en_pin_i & ~fault_q & (~q_trip_n | drop);
  assign kill      = fault_q | fault_set;

  pss_stepper #(.TMO_W(TMO_W)) u_step (
    .clk_i(clk_i), .rst_i(rst_i), .kill_i(kill),
    .target_i(target), .pg_i(rail_pg_i), .tmo_i(step_tmo_i),
    .rails_o(rails), .busy_o(busy), .drop_o(drop)
  );

  assign settled = ~busy & (rails == target);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      active_q <= 1'b0;
      fault_q  <= 1'b0;
      wake_q   <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      active_q <= int_pg_i & (active_q | auto_start_i | en_pin_i);
      fault_q  <= en_pin_i & (fault_q | fault_set);
      if (kill || state == PS_OFF) wake_q <= 1'b0;
      else if (settled)            wake_q <= 1'b1;
      if (kill || !(state == PS_ON || state == PS_IDLE)) ok_q <= 1'b0;
      else if (settled)                                  ok_q <= 1'b1;
    end
  end

  assign rails_o    = rails;
  assign wake_rel_o = wake_q;
  assign plat_ok_o  = ok_q;
  assign fault_o    = fault_q;
  assign ready_o    = active_q;
endmodule

// File: rtl/pwr_state_seq_chk.sv
module pwr_state_seq_chk
  import pss_pkg::*;
(
  input logic              clk_i,
  input logic              rst_i,
  input logic [RAIL_N-1:0] rails_o,
  input logic [RAIL_N-1:0] rail_dis_i,
  input logic              wake_rel_o,
  input logic              plat_ok_o,
  input logic              fault_o,
  input logic              ready_o
);
  // R1
  ok_needs_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    plat_ok_o |-> wake_rel_o);
  // R8
  one_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(rails_o & ~$past(rails_o)) <= 1);
  // R9
  one_fall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !fault_o |-> $countones($past(rails_o) & ~rails_o) <= 1);
  // R6
  no_masked_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rails_o & ~$past(rails_o) & $past(rail_dis_i)) == '0);
  // R10
  fault_all_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    fault_o |-> (rails_o == '0 && !wake_rel_o && !plat_ok_o));
  // R7
  not_ready_no_wake_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(ready_o) |-> !wake_rel_o);
endmodule

bind pwr_state_seq pwr_state_seq_chk u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .rails_o(rails_o), .rail_dis_i(rail_dis_i),
  .wake_rel_o(wake_rel_o), .plat_ok_o(plat_ok_o), .fault_o(fault_o),
  .ready_o(ready_o)
);

// File: tb/sim_pwr_state_seq.sv
module sim_pwr_state_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1, int_pg = 1'b0, auto_st = 1'b0, en_pin = 1'b0;
  logic       deep_n = 1'b1, mid_n = 1'b1, idle_n = 1'b1, trip_n = 1'b1, mem_lp = 1'b1;
  logic [7:0] dis = '0, pg = '0, drop_force = '0;
  logic [7:0] tmo = 8'd6;
  logic [7:0] rails;
  logic       wake, ok, fault, ready;

  pwr_state_seq u0 (
    .clk_i(clk), .rst_i(rst), .int_pg_i(int_pg), .auto_start_i(auto_st),
    .en_pin_i(en_pin), .sleep_deep_n_i(deep_n), .sleep_mid_n_i(mid_n),
    .sleep_idle_n_i(idle_n), .trip_n_i(trip_n), .mem_lp_i(mem_lp),
    .rail_dis_i(dis), .rail_pg_i(pg), .step_tmo_i(tmo),
    .rails_o(rails), .wake_rel_o(wake), .plat_ok_o(ok), .fault_o(fault),
    .ready_o(ready)
  );

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // rail plant: power-good follows enable after a per-rail delay; rail index 2 never reports good
  int dly [8] = '{3, 2, 4, 1, 2, 3, 2, 5};
  int pcnt [8] = '{default: 0};

  // behavioural reference
  bit       m_act, m_wseen, m_oseen, m_fault, m_busy, m_wake, m_ok;
  bit [7:0] m_en, m_good;
  int       m_idx, m_cnt;

  function automatic bit [7:0] want(int st, bit lp);
    case (st)
      1: return 8'h19;
      2: return lp ? 8'h79 : 8'h39;
      3: return 8'h78;
      4: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step();
    bit qd, qm, qi, qt, drop, fset, kill, settled;
    bit [7:0] tgt, nen;
    int st, k;
    if (rst) begin
      {m_act, m_wseen, m_oseen, m_fault, m_busy, m_wake, m_ok} = '0;
      m_en = '0; m_good = '0; m_idx = 0; m_cnt = 0;
      return;
    end
    qd = m_wseen && deep_n;
    qm = m_wseen && mid_n;
    qi = !m_oseen || idle_n;
    qt = !m_wseen || trip_n;
    if (!m_act || !en_pin) st = 0;
    else if (!qd) st = 1;
    else if (!qm) st = 2;
    else if (!qi) st = 3;
    else st = 4;
    tgt = want(st, mem_lp) & ~dis;
    drop = 0;
    for (int i = 0; i < 8; i++) if (m_good[i] && m_en[i] && !pg[i]) drop = 1;
    fset = m_act && en_pin && !m_fault && (!qt || drop);
    kill = fset || m_fault;
    settled = !m_busy && (m_en == tgt);
    nen = m_en;
    if (kill) begin
      nen = '0; m_busy = 0;
    end else if (m_busy) begin
      if (pg[m_idx] || m_cnt == int'(tmo)) m_busy = 0; else m_cnt++;
    end else begin
      k = -1;
      for (int i = 7; i >= 0; i--) if (tgt[i] && !m_en[i]) k = i;
      if (k >= 0) begin
        nen[k] = 1; m_busy = 1; m_idx = k; m_cnt = 0;
      end else begin
        for (int i = 0; i < 8; i++) if (m_en[i] && !tgt[i]) k = i;
        if (k >= 0) nen[k] = 0;
      end
    end
    m_good = (m_good | (m_en & pg)) & nen;
    m_en = nen;
    if (!en_pin) begin m_wseen = 0; m_oseen = 0; end
    else begin m_wseen = m_wseen || m_wake; m_oseen = m_oseen || m_ok; end
    if (kill || st == 0) m_wake = 0; else if (settled) m_wake = 1;
    if (kill || !(st == 3 || st == 4)) m_ok = 0; else if (settled) m_ok = 1;
    m_fault = en_pin && (m_fault || fset);
    m_act = int_pg && (m_act || auto_st || en_pin);
  endtask

  always @(posedge clk) model_step();

  // per-cycle comparison, then plant update
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R5 R8 R9 rails vs model", rails, m_en);
      chk("R1 wake vs model", wake, m_wake);
      chk("R1 ok vs model", ok, m_ok);
      chk("R10 R11 fault vs model", fault, m_fault);
      chk("R7 ready vs model", ready, m_act);
    end
    for (int i = 0; i < 8; i++) begin
      if (rails[i]) begin
        pcnt[i]++;
        pg[i] = (i != 2) && (pcnt[i] >= dly[i]) && !drop_force[i];
      end else begin
        pcnt[i] = 0;
        pg[i] = 1'b0;
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_wake();
    int g = 0;
    while (!wake && g < 1000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_ok();
    int g = 0;
    while (!ok && g < 1000) begin @(negedge clk); g++; end
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R12 reset state
    chk("R12 reset outputs", {ready, fault, ok, wake, rails}, 12'h000);
    int_pg = 1'b1;
    cyc(20);
    chk("R7 no ready without pin", ready, 1'b0);
    en_pin = 1'b1;
    cyc(3);
    chk("R7 ready with pin", ready, 1'b1);
    // boot with all sleep lines high: forced SOFT first
    wait_wake();
    chk("R2 base rails at first wake", rails, 8'h19);
    chk("R1 ok low in soft", ok, 1'b0);
    wait_ok();
    chk("R5 full set at first ok", rails, 8'hFF);
    cyc(40);
    chk("R8 timed-out rail still enabled", rails[2], 1'b1);
    chk("R1 handshakes in on", {wake, ok}, 2'b11);
    idle_n = 1'b0;
    cyc(60);
    chk("R5 idle set", rails, 8'h78);
    chk("R1 ok kept in idle", ok, 1'b1);
    idle_n = 1'b1;
    cyc(80);
    chk("R5 back to on", rails, 8'hFF);
    mid_n = 1'b0;
    cyc(40);
    chk("R5 suspend set lp memory", rails, 8'h79);
    chk("R1 suspend handshakes", {wake, ok}, 2'b10);
    deep_n = 1'b0;
    cyc(40);
    chk("R9 down to base", rails, 8'h19);
    dis = 8'h20;
    deep_n = 1'b1;
    cyc(60);
    chk("R6 masked memory rail", rails, 8'h59);
    dis = 8'h00;
    mid_n = 1'b1;
    cyc(100);
    chk("R5 on before drop", rails, 8'hFF);
    drop_force[4] = 1'b1;
    cyc(5);
    chk("R10 drop shutdown", {fault, ok, wake, rails}, 11'h400);
    drop_force[4] = 1'b0;
    cyc(20);
    chk("R11 fault held", {fault, rails}, 9'h100);
    en_pin = 1'b0;
    cyc(3);
    chk("R11 fault cleared by pin", fault, 1'b0);
    // memory type 0
    mem_lp = 1'b0;
    mid_n = 1'b0;
    en_pin = 1'b1;
    cyc(120);
    chk("R5 suspend set std memory", rails, 8'h39);
    en_pin = 1'b0;
    cyc(20);
    chk("R9 all off with pin low", rails, 8'h00);
    // trip ignored until wake rises
    mid_n = 1'b1;
    trip_n = 1'b0;
    en_pin = 1'b1;
    wait_wake();
    chk("R4 trip ignored before wake", fault, 1'b0);
    cyc(4);
    chk("R10 trip shutdown", {fault, wake, rails}, 10'h200);
    en_pin = 1'b0;
    trip_n = 1'b1;
    cyc(5);
    // idle forced high until first ok
    mem_lp = 1'b1;
    idle_n = 1'b0;
    en_pin = 1'b1;
    wait_ok();
    chk("R3 idle ignored before ok", rails, 8'hFF);
    cyc(60);
    chk("R3 idle honoured after ok", rails, 8'h78);
    // auto start
    en_pin = 1'b0;
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    auto_st = 1'b1;
    cyc(3);
    chk("R7 auto ready without pin", {ready, rails}, 9'h100);
    int_pg = 1'b0;
    cyc(2);
    chk("R7 ready drops with supplies", ready, 1'b0);
    finish_run();
  end
endmodule